// File: doc/BRIEF.md
# Predicated Vector Integer Compare Unit

This unit compares two integer vector operands lane by lane under a governing predicate. It produces a result predicate that holds one bit per vector byte, along with four condition flags. The vector width is a build parameter and must be a multiple of 64 bits, from 128 to 512 bits. The element size, the comparison condition and a wide-comparand mode are chosen at run time for each operation.

A one-cycle start pulse captures both operands, the governing predicate and the control inputs. The unit then works through one 64-bit chunk per clock, from the highest chunk down to chunk 0. As each chunk finishes, its eight predicate bits are written, and its result bits and active-lane bits are passed to a flag accumulator. When the lowest chunk is done, a one-cycle done pulse marks the full predicate and the flags as valid. Both stay unchanged until the next operation is accepted.

In wide mode, every narrow element of the first operand is compared against the 64-bit element of the second operand that covers the same 64-bit segment. Combinations that the unit does not support raise an illegal indication and give an empty result. The reset input is asynchronous and active-low; its release is expected to be synchronised to the clock upstream.

Top module: `vcmp_pred_unit`

## Requirements
- R1: After reset, busy_o, done_o and illegal_o are 0, pred_o is all zeros and flags_o ({N,Z,C,V}) is 4'b0110.
- R2: start_i is accepted only while busy_o is 0; a start while busy has no effect. Call the edge that accepts a start edge 1. done_o is then high for exactly one cycle, beginning at rising edge NCHUNK+1, where NCHUNK = VL_BITS/64.
- R3: The size code sets the element size S: 0 is byte (S=1), 1 is halfword (S=2), 2 is word (S=4), 3 is doubleword (S=8). An element at byte offset k, with k a multiple of S, reports its result in pred_o bit k. All other pred_o bits are 0.
- R4: Only governing bit k is consulted for the element at byte offset k; the other governing bits in its group are ignored. An element whose governing bit is 0 yields 0.
- R5: Outside wide mode, the condition codes at every size are 0 EQ, 1 NE, 2 signed greater, 3 signed greater-or-equal, 4 unsigned greater, 5 unsigned greater-or-equal. Each is evaluated as first operand against second operand.
- R6: With wide_i=1, the comparand is the 64-bit segment of the second operand that contains the element. The element is sign-extended for signed codes and zero-extended for the other codes.
- R7: Wide mode adds code 6 signed less, 7 signed less-or-equal, 8 unsigned less, 9 unsigned less-or-equal.
- R8: The flags are defined over elements in ascending byte offset across all chunks. N is the result of the lowest active element. Z is 1 exactly when no pred_o bit is set. C is the inverse of the result of the highest active element. V is 0.
- R9: When no element is active, pred_o is zero and flags_o is 4'b0110.
- R10: An operation is illegal when it uses wide mode with size 3, codes 6 to 9 outside wide mode, or codes 10 to 15. An illegal operation drives illegal_o to 1 until the next accepted start, gives pred_o all zeros and flags_o 4'b0110, and keeps the R2 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse that captures the operands and controls |
| size_i | input | 2 | Element size code |
| cond_i | input | 4 | Condition code |
| wide_i | input | 1 | Wide-comparand mode |
| opa_i | input | VL_BITS | First vector operand |
| opb_i | input | VL_BITS | Second vector operand |
| gov_i | input | VL_BITS/8 | Governing predicate, one bit per byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Captured operation is unsupported |
| pred_o | output | VL_BITS/8 | Result predicate |
| flags_o | output | 4 | {N,Z,C,V} |

## Verification
The bench builds the unit with VL_BITS=256, which gives four chunks. This lets the lowest and highest active elements sit in different chunks, so the backward chunk walk and the ordering of the flags can be checked. It also leaves four independent wide segments per operand, so a per-segment comparand can be told apart from a shared one. With this setting the start-while-busy case, the timing of the done pulse and every size, condition and wide combination, legal or not, can all be reached.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;
  localparam logic [1:0] SZ_D = 2'd3;

  localparam logic [3:0] CC_EQ = 4'd0;
  localparam logic [3:0] CC_NE = 4'd1;
  localparam logic [3:0] CC_GT = 4'd2;
  localparam logic [3:0] CC_GE = 4'd3;
  localparam logic [3:0] CC_HI = 4'd4;
  localparam logic [3:0] CC_HS = 4'd5;
  localparam logic [3:0] CC_LT = 4'd6;
  localparam logic [3:0] CC_LE = 4'd7;
  localparam logic [3:0] CC_LO = 4'd8;
  localparam logic [3:0] CC_LS = 4'd9;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } cmp_flags_t;

  function automatic logic cc_is_signed(input logic [3:0] cc);
    return (cc == CC_GT) || (cc == CC_GE) || (cc == CC_LT) || (cc == CC_LE);
  endfunction

  function automatic logic op_legal(input logic [1:0] sz, input logic [3:0] cc,
                                    input logic wide);
    logic ok;
    if (cc > CC_LS)      ok = 1'b0;
    else if (wide)       ok = (sz != SZ_D);
    else                 ok = (cc <= CC_HS);
    return ok;
  endfunction

  function automatic logic [7:0] lead_lanes(input logic [1:0] sz);
    logic [7:0] m;
    case (sz)
      SZ_B:    m = 8'hFF;
      SZ_H:    m = 8'h55;
      SZ_W:    m = 8'h11;
      default: m = 8'h01;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/vcmp_seq.sv
module vcmp_seq #(
  parameter int NCHUNK = 4,
  localparam int CW = $clog2(NCHUNK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          accept_o,
  output logic          step_o,
  output logic [CW-1:0] idx_o,
  output logic          busy_o,
  output logic          done_o
);

  logic          busy_q, busy_d;
  logic [CW-1:0] idx_q, idx_d;
  logic          done_q, done_d;
  logic          accept;

  assign accept = start_i & ~busy_q;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      idx_d  = CW'(NCHUNK - 1);
    end else if (busy_q) begin
      if (idx_q == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        idx_d = idx_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  assign accept_o = accept;
  assign step_o   = busy_q;
  assign idx_o    = idx_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> (busy_q && idx_q == CW'(NCHUNK - 1)));

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (int'(idx_q) < NCHUNK));

endmodule

// File: rtl/vcmp_chunk_cmp.sv
module vcmp_chunk_cmp
  import vcmp_pkg::*;
(
  input  logic [63:0] a_i,
  input  logic [63:0] b_i,
  input  logic [1:0]  size_i,
  input  logic [3:0]  cond_i,
  input  logic        wide_i,
  input  logic        legal_i,
  input  logic [7:0]  gov_i,
  output logic [7:0]  res_o,
  output logic [7:0]  act_o
);

  logic [7:0] raw;
  logic       sgn;

  assign sgn = cc_is_signed(cond_i);

  for (genvar j = 0; j < 8; j++) begin : g_lane
    logic [63:0] sa, sb;
    logic [64:0] ea, eb;
    logic        eq, gt, lt;

    always_comb begin
      sa = a_i >> (8 * j);
      sb = b_i >> (8 * j);
      case (size_i)
        SZ_B: begin
          ea = {{57{sgn & sa[7]}},  sa[7:0]};
          eb = {{57{sgn & sb[7]}},  sb[7:0]};
        end
        SZ_H: begin
          ea = {{49{sgn & sa[15]}}, sa[15:0]};
          eb = {{49{sgn & sb[15]}}, sb[15:0]};
        end
        SZ_W: begin
          ea = {{33{sgn & sa[31]}}, sa[31:0]};
          eb = {{33{sgn & sb[31]}}, sb[31:0]};
        end
        default: begin
          ea = {sgn & sa[63], sa};
          eb = {sgn & sb[63], sb};
        end
      endcase
      if (wide_i) eb = {sgn & b_i[63], b_i};
      eq = (ea == eb);
      gt = ($signed(ea) > $signed(eb));
      lt = ($signed(ea) < $signed(eb));
      case (cond_i)
        CC_EQ:        raw[j] = eq;
        CC_NE:        raw[j] = ~eq;
        CC_GT, CC_HI: raw[j] = gt;
        CC_GE, CC_HS: raw[j] = gt | eq;
        CC_LT, CC_LO: raw[j] = lt;
        CC_LE, CC_LS: raw[j] = lt | eq;
        default:      raw[j] = 1'b0;
      endcase
    end
  end

  assign act_o = gov_i & lead_lanes(size_i) & {8{legal_i}};
  assign res_o = raw & act_o;

endmodule

// File: rtl/vcmp_flag_acc.sv
module vcmp_flag_acc
  import vcmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       step_i,
  input  logic [7:0] d_i,
  input  logic [7:0] g_i,
  output cmp_flags_t flags_o
);

  logic seen_q, seen_d;
  logic n_q, n_d;
  logic any_q, any_d;
  logic c_q, c_d;
  logic d_hi, d_lo;

  always_comb begin
    d_hi = 1'b0;
    for (int i = 0; i < 8; i++) if (g_i[i]) d_hi = d_i[i];
    d_lo = 1'b0;
    for (int i = 7; i >= 0; i--) if (g_i[i]) d_lo = d_i[i];
  end

  always_comb begin
    seen_d = seen_q;
    n_d    = n_q;
    any_d  = any_q;
    c_d    = c_q;
    if (clr_i) begin
      seen_d = 1'b0;
      n_d    = 1'b0;
      any_d  = 1'b0;
      c_d    = 1'b1;
    end else if (step_i && (g_i != 8'h00)) begin
      if (!seen_q) c_d = ~d_hi;
      seen_d = 1'b1;
      any_d  = any_q | (|(d_i & g_i));
      n_d    = d_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      n_q    <= 1'b0;
      any_q  <= 1'b0;
      c_q    <= 1'b1;
    end else begin
      seen_q <= seen_d;
      n_q    <= n_d;
      any_q  <= any_d;
      c_q    <= c_d;
    end
  end

  assign flags_o = '{n: n_q, z: ~any_q, c: c_q, v: 1'b0};

  // R9
  empty_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (c_q && !n_q && !any_q));

  // R8
  res_needs_gov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i && (d_i & ~g_i) == 8'h00 && (d_i & g_i) != 8'h00) |=> any_q);

endmodule

// File: rtl/vcmp_pred_unit.sv
module vcmp_pred_unit
  import vcmp_pkg::*;
#(
  parameter int VL_BITS = 256,
  localparam int NCHUNK = VL_BITS / 64,
  localparam int PBITS  = VL_BITS / 8,
  localparam int CW     = $clog2(NCHUNK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [1:0]         size_i,
  input  logic [3:0]         cond_i,
  input  logic               wide_i,
  input  logic [VL_BITS-1:0] opa_i,
  input  logic [VL_BITS-1:0] opb_i,
  input  logic [PBITS-1:0]   gov_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               illegal_o,
  output logic [PBITS-1:0]   pred_o,
  output logic [3:0]         flags_o
);

  logic               accept, step;
  logic [CW-1:0]      idx;

  logic [VL_BITS-1:0] opa_q, opb_q;
  logic [PBITS-1:0]   gov_q;
  logic [1:0]         size_q;
  logic [3:0]         cond_q;
  logic               wide_q;
  logic               ill_q, ill_d;
  logic [PBITS-1:0]   pred_q, pred_d;

  logic [63:0]        a_chunk, b_chunk;
  logic [7:0]         g_chunk, res8, act8;
  cmp_flags_t         flags;

  vcmp_seq #(.NCHUNK(NCHUNK)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_o (accept),
    .step_o   (step),
    .idx_o    (idx),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  always_ff @(posedge clk) begin
    if (accept) begin
      opa_q  <= opa_i;
      opb_q  <= opb_i;
      gov_q  <= gov_i;
      size_q <= size_i;
      cond_q <= cond_i;
      wide_q <= wide_i;
    end
  end

  assign a_chunk = opa_q[{idx, 6'b0} +: 64];
  assign b_chunk = opb_q[{idx, 6'b0} +: 64];
  assign g_chunk = gov_q[{idx, 3'b0} +: 8];

  vcmp_chunk_cmp u_cmp (
    .a_i     (a_chunk),
    .b_i     (b_chunk),
    .size_i  (size_q),
    .cond_i  (cond_q),
    .wide_i  (wide_q),
    .legal_i (~ill_q),
    .gov_i   (g_chunk),
    .res_o   (res8),
    .act_o   (act8)
  );

  vcmp_flag_acc u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (accept),
    .step_i  (step),
    .d_i     (res8),
    .g_i     (act8),
    .flags_o (flags)
  );

  always_comb begin
    ill_d  = ill_q;
    pred_d = pred_q;
    if (accept) begin
      ill_d  = ~op_legal(size_i, cond_i, wide_i);
      pred_d = '0;
    end else if (step) begin
      pred_d[{idx, 3'b0} +: 8] = res8;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ill_q  <= 1'b0;
      pred_q <= '0;
    end else begin
      ill_q  <= ill_d;
      pred_q <= pred_d;
    end
  end

  assign illegal_o = ill_q;
  assign pred_o    = pred_q;
  assign flags_o   = flags;

  // R4
  pred_in_gov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((pred_o & ~gov_q) == '0));

  // R3
  pred_lead_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((pred_o & ~{NCHUNK{lead_lanes(size_q)}}) == '0));

  // R8
  zflag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (flags_o[2] == (pred_o == '0)) && !flags_o[0]);

  // R10
  illegal_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && illegal_o) |-> (pred_o == '0 && flags_o == 4'b0110));

endmodule

// File: tb/tb_vcmp_pred_unit.sv
`timescale 1ns/1ps
module tb_vcmp_pred_unit;

  localparam int VL  = 256;
  localparam int NCH = VL / 64;
  localparam int PB  = VL / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    size_i = '0;
  logic [3:0]    cond_i = '0;
  logic          wide_i = 1'b0;
  logic [VL-1:0] opa_i = '0;
  logic [VL-1:0] opb_i = '0;
  logic [PB-1:0] gov_i = '0;
  logic          busy_o, done_o, illegal_o;
  logic [PB-1:0] pred_o;
  logic [3:0]    flags_o;

  int checks = 0;
  int errors = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #2 clk = ~clk;

  vcmp_pred_unit #(.VL_BITS(VL)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i),
    .cond_i(cond_i), .wide_i(wide_i), .opa_i(opa_i), .opb_i(opb_i),
    .gov_i(gov_i), .busy_o(busy_o), .done_o(done_o),
    .illegal_o(illegal_o), .pred_o(pred_o), .flags_o(flags_o)
  );

  // Encodings: size 0 B,1 H,2 W,3 D; tbl entry = {gov_all, wide, size[1:0], cond[3:0]}
  localparam int NT = 27;
  localparam logic [7:0] TBL [NT] = '{
    8'h00, 8'h11, 8'h22, 8'h33, 8'h04, 8'h15, 8'h30, 8'h02, 8'h83,
    8'h94, 8'hA5, 8'hB2, 8'h24, 8'h13,
    8'h40, 8'h51, 8'h62, 8'h43, 8'h54, 8'h65, 8'h46, 8'h57, 8'h68,
    8'h49, 8'hC6, 8'hD9, 8'hE7
  };

  function automatic logic [63:0] nxt(input logic [63:0] s);
    logic [63:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  function automatic logic [64:0] ext(input logic [63:0] x, input logic [1:0] sz, input logic s);
    case (sz)
      2'd0:    return {{57{s & x[7]}}, x[7:0]};
      2'd1:    return {{49{s & x[15]}}, x[15:0]};
      2'd2:    return {{33{s & x[31]}}, x[31:0]};
      default: return {s & x[63], x};
    endcase
  endfunction

  task automatic model(input logic [1:0] sz, input logic [3:0] cc, input logic w,
                       input logic [VL-1:0] a, input logic [VL-1:0] b, input logic [PB-1:0] g,
                       output logic [PB-1:0] p, output logic [3:0] f, output logic ill);
    logic first, anyr, n, c, s, r;
    logic [64:0] ea, eb;
    int sb;
    ill = (cc > 4'd9) || (w && sz == 2'd3) || (!w && cc > 4'd5);
    s = (cc == 4'd2) || (cc == 4'd3) || (cc == 4'd6) || (cc == 4'd7);
    sb = 1 << sz;
    p = '0; first = 1'b1; anyr = 1'b0; n = 1'b0; c = 1'b1;
    if (!ill) begin
      for (int k = 0; k < PB; k++) begin
        if ((k % sb) == 0 && g[k]) begin
          ea = ext(64'(a >> (8 * k)), sz, s);
          eb = w ? ext(64'(b >> (64 * (k / 8))), 2'd3, s) : ext(64'(b >> (8 * k)), sz, s);
          case (cc)
            4'd0: r = (ea == eb);
            4'd1: r = (ea != eb);
            4'd2, 4'd4: r = ($signed(ea) > $signed(eb));
            4'd3, 4'd5: r = ($signed(ea) >= $signed(eb));
            4'd6, 4'd8: r = ($signed(ea) < $signed(eb));
            default:    r = ($signed(ea) <= $signed(eb));
          endcase
          p[k] = r;
          if (first) begin n = r; first = 1'b0; end
          c = ~r;
          anyr = anyr | r;
        end
      end
    end
    f = {n, ~anyr, c, 1'b0};
  endtask

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [VL-1:0] act, input logic [VL-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] sz, input logic [3:0] cc, input logic w,
                       input logic [VL-1:0] a, input logic [VL-1:0] b, input logic [PB-1:0] g);
    size_i = sz; cond_i = cc; wide_i = w; opa_i = a; opb_i = b; gov_i = g;
  endtask

  task automatic wait_done(output int cnt);
    cnt = 1;
    @(negedge clk);
    while (!done_o && cnt < 64) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic run_op(input logic [1:0] sz, input logic [3:0] cc, input logic w,
                        input logic [VL-1:0] a, input logic [VL-1:0] b, input logic [PB-1:0] g,
                        input string req);
    logic [PB-1:0] ep;
    logic [3:0] ef;
    logic ei;
    int cnt;
    model(sz, cc, w, a, b, g, ep, ef, ei);
    @(negedge clk);
    drive(sz, cc, w, a, b, g);
    start_i = 1'b1;
    @(posedge clk);
    #1 start_i = 1'b0;
    wait_done(cnt);
    chk(cnt == NCH + 1, "R2", "done latency", VL'(cnt), VL'(NCH + 1));
    chk(pred_o == ep, req, "pred", VL'(pred_o), VL'(ep));
    chk(flags_o == ef, "R8", "flags", VL'(flags_o), VL'(ef));
    chk(illegal_o == ei, "R10", "illegal", VL'(illegal_o), VL'(ei));
    @(negedge clk);
    chk(!done_o, "R2", "done one cycle", VL'(done_o), '0);
  endtask

  function automatic logic [VL-1:0] rvec(input logic [63:0] seed);
    logic [VL-1:0] v;
    logic [63:0] s;
    s = seed;
    for (int i = 0; i < NCH; i++) begin
      s = nxt(s);
      v[64*i +: 64] = s;
    end
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [VL-1:0] a, b, m;
    logic [PB-1:0] g;
    logic [PB-1:0] ep;
    logic [3:0] ef;
    logic ei;
    int cnt;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy_o, "R1", "busy", VL'(busy_o), '0);
    chk(!done_o, "R1", "done", VL'(done_o), '0);
    chk(!illegal_o, "R1", "illegal", VL'(illegal_o), '0);
    chk(pred_o == '0, "R1", "pred", VL'(pred_o), '0);
    chk(flags_o == 4'b0110, "R1", "flags", VL'(flags_o), VL'(4'b0110));
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R3 R5 R6 R7
    for (int t = 0; t < NT; t++) begin
      logic [1:0] sz;
      logic [3:0] cc;
      logic w;
      sz = TBL[t][5:4]; cc = TBL[t][3:0]; w = TBL[t][6];
      rng = nxt(rng);
      a = rvec(rng);
      rng = nxt(rng);
      m = rvec(rng) & rvec(nxt(rng)) & rvec(nxt(nxt(rng)));
      if (!w) begin
        b = a ^ m;
      end else begin
        b = rvec(nxt(rng ^ 64'h55));
        for (int s2 = 0; s2 < NCH; s2 += 2)
          b[64*s2 +: 64] = ext(a[64*s2 +: 64], sz, s2[1])[63:0];
      end
      g = TBL[t][7] ? '1 : PB'(rvec(nxt(rng ^ 64'hA5)));
      run_op(sz, cc, w, a, b, g, w ? (cc > 4'd5 ? "R7" : "R6") : (t % 2 == 0 ? "R5" : "R3"));
    end

    // R4 / R9: halfword, only non-lead governing bits set
    a = rvec(64'h1234);
    run_op(2'd1, 4'd0, 1'b0, a, a, {(PB/2){2'b10}}, "R4");
    chk(pred_o == '0 && flags_o == 4'b0110, "R9", "no active", VL'({pred_o, flags_o}), VL'(4'b0110));

    // R8: active elements in different chunks, both true
    g = '0; g[3] = 1'b1; g[30] = 1'b1;
    run_op(2'd0, 4'd0, 1'b0, a, a, g, "R8");
    chk(flags_o == 4'b1000, "R8", "first/last true", VL'(flags_o), VL'(4'b1000));
    // highest active false
    b = a; b[8*30 +: 8] = ~a[8*30 +: 8];
    run_op(2'd0, 4'd0, 1'b0, a, b, g, "R8");
    chk(flags_o == 4'b1010, "R8", "last false", VL'(flags_o), VL'(4'b1010));

    // R6: zero elements against all-ones segments
    run_op(2'd0, 4'd2, 1'b1, '0, '1, '1, "R6");
    chk(pred_o == '1, "R6", "signed 0 > -1", VL'(pred_o), VL'({PB{1'b1}}));
    run_op(2'd0, 4'd4, 1'b1, '0, '1, '1, "R6");
    chk(pred_o == '0, "R6", "unsigned 0 > max", VL'(pred_o), '0);

    // R10 illegal combinations
    run_op(2'd3, 4'd0, 1'b1, a, a, '1, "R10");
    run_op(2'd0, 4'd7, 1'b0, a, a, '1, "R10");
    run_op(2'd2, 4'd12, 1'b1, a, a, '1, "R10");
    chk(illegal_o, "R10", "illegal held", VL'(illegal_o), VL'(1));

    // R2: start while busy is ignored
    model(2'd0, 4'd0, 1'b0, a, a, '1, ep, ef, ei);
    @(negedge clk);
    drive(2'd0, 4'd0, 1'b0, a, a, '1);
    start_i = 1'b1;
    @(posedge clk);
    #1 start_i = 1'b0;
    @(negedge clk);
    drive(2'd0, 4'd1, 1'b0, a, ~a, '1);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cnt = 2;
    while (!done_o && cnt < 64) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == NCH + 1, "R2", "busy start latency", VL'(cnt), VL'(NCH + 1));
    chk(pred_o == ep, "R2", "busy start ignored", VL'(pred_o), VL'(ep));
    @(negedge clk);
    chk(!busy_o && !done_o, "R2", "idle after", VL'({busy_o, done_o}), '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule